// File: doc/BRIEF.md
# 10BASE-T Manchester Transmit Serializer with Half-Duplex Loopback

This block is the digital transmit path of a 10 Mb/s twisted-pair port. A MAC hands it 4-bit nibbles over an MII-style interface. The block serializes each nibble least-significant bit first and Manchester-encodes every bit into two half-bit cells on a single line output that feeds the analog driver. The core clock `clk` runs at the half-bit rate, nominally 20 MHz. A free-running half-bit counter divides it by eight to produce the 2.5 MHz nibble clock `tx_clk`, which the MAC uses to pace its data. The block samples `tx_en` and `txd` on exactly one `clk` edge per nibble, the nibble boundary. That boundary is the edge at which `tx_clk` rises.

A two-state machine sequences the work. In state IDLE the line is held low without transitions and `tx_active` is low. Transition IDLE->SEND is taken at a nibble boundary where `tx_en` is high, and the nibble on `txd` is loaded. In state SEND the block encodes the loaded nibble. It stays in SEND (SEND->SEND, loading the next nibble) at every boundary where `tx_en` is still high. Transition SEND->IDLE is taken at the first boundary where `tx_en` is low. A nibble that has started is therefore always sent in full.

When `half_duplex` is high, the nibble being sent is returned on `rxd` with `rx_dv` high, as a legacy half-duplex MAC expects. The collision output `col` stays low throughout. In full-duplex mode the loopback outputs stay quiet.

Top module: `mx_tx_top`

## Requirements
- R1: `tx_en` and `txd` are sampled only at the nibble boundary, the `clk` edge on which the half-bit counter wraps from 7 to 0. Their values at any other edge have no effect on any output.
- R2: The four bits of a loaded nibble go out least-significant bit first. Bit k occupies half-bit cells 2k and 2k+1 of the nibble period.
- R3: In state SEND each bit is Manchester encoded. A 1 is sent as the line low in the first half-bit cell and high in the second. A 0 is sent as high, then low. The line therefore always toggles in the middle of a bit cell.
- R4: In state IDLE `tx_line` is 0 with no transitions.
- R5: `tx_active` is 1 exactly while the state is SEND. When `tx_en` is low at a boundary, the nibble that just ended was complete, and the block enters IDLE.
- R6: With `half_duplex` = 1 and state SEND, `rx_dv` = 1 and `rxd` equals the nibble currently being sent.
- R7: With `half_duplex` = 0, or in state IDLE, `rx_dv` = 0 and `rxd` = 0.
- R8: `col` is 0 at all times, including during loopback.
- R9: `tx_clk` is high during half-bit cells 0 to 3 and low during cells 4 to 7, giving one period per 8 `clk` cycles. It rises right after each boundary edge.
- R10: While `rst_n` is low, the state is IDLE, the counter is 0, `tx_line`, `tx_active`, `rx_dv` and `rxd` are 0, and `tx_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock (nominally 20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex | input | 1 | 1 = half duplex, loopback enabled; 0 = full duplex |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_clk | output | 1 | Nibble clock to the MAC (clk / 8) |
| tx_line | output | 1 | Manchester-encoded half-bit line output |
| tx_active | output | 1 | High while a nibble is being sent |
| rxd | output | 4 | Loopback receive nibble |
| rx_dv | output | 1 | Loopback receive data valid |
| col | output | 1 | Collision indication, held low |

## Verification
The hardest situation to reach is a change of `tx_en` or `txd` between boundaries. Examples are a pulse of `tx_en` that falls before the next boundary, or data that changes every cycle. In either case only the single sampled edge may matter. The bench gets there in two ways: it drives `txd` with new random values on every `clk` cycle while `tx_en` is held, and it toggles `tx_en` randomly each cycle with no alignment to `tx_clk`. It also flips `half_duplex` in the middle of frames, so that the loopback outputs must follow the mode as it changes and not latch it.

// File: rtl/mx_pkg.sv
package mx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } mx_state_e;
endpackage

// File: rtl/mx_bit_timer.sv
// Half-bit counter: locates the nibble boundary, the bit index and the cell half.
module mx_bit_timer #(
    parameter int NIB_W = 4,
    localparam int HB_N  = 2 * NIB_W,
    localparam int CNT_W = $clog2(HB_N),
    localparam int IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             nib_edge,
    output logic [IDX_W-1:0] bit_idx,
    output logic             half_second,
    output logic             nib_clk
);
    localparam logic [CNT_W-1:0] HB_LAST = CNT_W'(HB_N - 1);

    logic [CNT_W-1:0] hb_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_cnt <= '0;
        end else if (hb_cnt == HB_LAST) begin
            hb_cnt <= '0;
        end else begin
            hb_cnt <= hb_cnt + 1'b1;
        end
    end

    always_comb begin
        nib_edge    = (hb_cnt == HB_LAST);
        bit_idx     = hb_cnt[CNT_W-1:1];
        half_second = hb_cnt[0];
        nib_clk     = (hb_cnt < CNT_W'(NIB_W));
    end
endmodule

// File: rtl/mx_nib_fsm.sv
// Transmit sequencer: IDLE/SEND, nibble capture at the boundary only.
module mx_nib_fsm
    import mx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_edge,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output mx_state_e        state,
    output logic [NIB_W-1:0] nib
);
    mx_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (nib_edge && tx_en)  state_nx = ST_SEND;
            ST_SEND: if (nib_edge && !tx_en) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib <= '0;
        end else if (nib_edge && tx_en) begin
            nib <= txd;
        end
    end
endmodule

// File: rtl/mx_line_enc.sv
// Output process: Manchester line, active flag and half-duplex loopback.
module mx_line_enc
    import mx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  mx_state_e        state,
    input  logic [NIB_W-1:0] nib,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             half_second,
    input  logic             half_duplex,
    output logic             line,
    output logic             active,
    output logic [NIB_W-1:0] lb_data,
    output logic             lb_valid,
    output logic             collision
);
    logic cur_bit;

    always_comb begin
        cur_bit   = nib[bit_idx];
        line      = 1'b0;
        active    = 1'b0;
        lb_data   = '0;
        lb_valid  = 1'b0;
        collision = 1'b0;
        unique case (state)
            ST_IDLE: begin
                line = 1'b0;
            end
            ST_SEND: begin
                active = 1'b1;
                line   = half_second ? cur_bit : ~cur_bit;
                if (half_duplex) begin
                    lb_valid = 1'b1;
                    lb_data  = nib;
                end
            end
        endcase
    end
endmodule

// File: rtl/mx_tx_top.sv
module mx_tx_top
    import mx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_duplex,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             tx_clk,
    output logic             tx_line,
    output logic             tx_active,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             col
);
    logic             nib_edge;
    logic [IDX_W-1:0] bit_idx;
    logic             half_second;
    mx_state_e        state;
    logic [NIB_W-1:0] nib;

    mx_bit_timer #(.NIB_W(NIB_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .nib_edge    (nib_edge),
        .bit_idx     (bit_idx),
        .half_second (half_second),
        .nib_clk     (tx_clk)
    );

    mx_nib_fsm #(.NIB_W(NIB_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_edge (nib_edge),
        .tx_en    (tx_en),
        .txd      (txd),
        .state    (state),
        .nib      (nib)
    );

    mx_line_enc #(.NIB_W(NIB_W)) u_enc (
        .state       (state),
        .nib         (nib),
        .bit_idx     (bit_idx),
        .half_second (half_second),
        .half_duplex (half_duplex),
        .line        (tx_line),
        .active      (tx_active),
        .lb_data     (rxd),
        .lb_valid    (rx_dv),
        .collision   (col)
    );
endmodule

// File: rtl/mx_tx_checker.sv
module mx_tx_checker #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_duplex,
    input logic             nib_edge,
    input logic             half_second,
    input logic             tx_clk,
    input logic             tx_line,
    input logic             tx_active,
    input logic [NIB_W-1:0] rxd,
    input logic             rx_dv
);
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (tx_line == 1'b0));

    p_mid_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && half_second && $past(tx_active)) |-> (tx_line != $past(tx_line)));

    p_dv_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> (tx_active && half_duplex));

    p_rxd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |-> (rxd == '0));

    p_state_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_edge |=> $stable(tx_active));

    p_clk_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nib_edge |=> $rose(tx_clk));
endmodule

bind mx_tx_top mx_tx_checker #(.NIB_W(NIB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_duplex (half_duplex),
    .nib_edge    (nib_edge),
    .half_second (half_second),
    .tx_clk      (tx_clk),
    .tx_line     (tx_line),
    .tx_active   (tx_active),
    .rxd         (rxd),
    .rx_dv       (rx_dv)
);

// File: tb/mx_tx_top_tb.sv
module mx_tx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_duplex = 1'b1;
    logic       tx_en = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_clk, tx_line, tx_active, rx_dv, col;
    logic [3:0] rxd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_ph = 0;
    int m_act = 0;
    int m_nib = 0;

    always #10 clk = ~clk;

    mx_tx_top u_dut (
        .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex),
        .tx_en(tx_en), .txd(txd), .tx_clk(tx_clk), .tx_line(tx_line),
        .tx_active(tx_active), .rxd(rxd), .rx_dv(rx_dv), .col(col)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model: boundary sampling (R1), state update (R5)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            m_act = 0;
        end else begin
            if (m_ph == 7) begin
                m_act = tx_en ? 1 : 0;
                if (tx_en) m_nib = int'(txd);
            end
            m_ph = (m_ph + 1) % 8;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            int bitv, exp_line;
            if (!rst_n) begin
                chk("R10", "tx_clk", int'(tx_clk), 1);
                chk("R10", "tx_line", int'(tx_line), 0);
                chk("R10", "tx_active", int'(tx_active), 0);
                chk("R10", "rx_dv", int'(rx_dv), 0);
                chk("R10", "rxd", int'(rxd), 0);
            end else begin
                chk("R9", "tx_clk", int'(tx_clk), (m_ph < 4) ? 1 : 0);
                chk("R1 R5", "tx_active", int'(tx_active), m_act);
                chk("R8", "col", int'(col), 0);
                if (m_act != 0) begin
                    bitv = (m_nib >> (m_ph / 2)) & 1;
                    exp_line = (m_ph % 2 == 0) ? (1 - bitv) : bitv;
                    chk("R2 R3", "tx_line", int'(tx_line), exp_line);
                end else begin
                    chk("R4", "tx_line", int'(tx_line), 0);
                end
                if (m_act != 0 && half_duplex) begin
                    chk("R6", "rx_dv", int'(rx_dv), 1);
                    chk("R6", "rxd", int'(rxd), m_nib);
                end else begin
                    chk("R7", "rx_dv", int'(rx_dv), 0);
                    chk("R7", "rxd", int'(rxd), 0);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        int pat [12] = '{4'h0, 4'hF, 4'h5, 4'hA, 4'h1, 4'h8, 4'h3, 4'hC, 4'h7, 4'hE, 4'h9, 4'h6};
        step(5);
        rst_n = 1'b1;
        // R1: garbage data with tx_en low is ignored
        for (int i = 0; i < 30; i++) begin
            txd = 4'($urandom());
            step(1);
        end
        // half-duplex frame (R6), then full-duplex frame (R7)
        for (int mode = 1; mode >= 0; mode--) begin
            half_duplex = mode[0];
            tx_en = 1'b1;
            for (int i = 0; i < 12; i++) begin
                txd = 4'(pat[i]);
                step(8);
            end
            tx_en = 1'b0;
            txd = 4'h0;
            step(40);
        end
        // R1: data changes every cycle, mode flips mid-frame
        tx_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            txd = 4'($urandom());
            if (i % 37 == 0) half_duplex = ~half_duplex;
            step(1);
        end
        // R1, R5: tx_en toggles without alignment
        for (int i = 0; i < 800; i++) begin
            tx_en = ($urandom() % 3) != 0;
            txd = 4'($urandom());
            if (i % 53 == 0) half_duplex = ~half_duplex;
            step(1);
        end
        tx_en = 1'b0;
        step(30);
        // R10: reset in the middle of a frame
        tx_en = 1'b1;
        txd = 4'hB;
        step(20);
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(24);
        tx_en = 1'b0;
        step(24);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        done = 1;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule